// File: doc/BRIEF.md
# Pattern Condition Trigger Sequencer

This block produces a trigger from two parallel pattern conditions. Each condition watches 16 channel logic bits and one external bit. For every bit, a condition asks for High, asks for Low, or ignores the bit. A condition counts as having occurred either when it becomes true (entry) or when it becomes false (exit). The selection is made separately for each condition.

A small sequencer combines these events into a trigger. The four modes are:
- A followed by the n-th B event.
- A, then a programmed delay, then the first B event.
- A per-bit edge OR that counts only while condition A is true.
- A plain per-bit edge OR.

All timing uses an input tick enable of 500 ns. After the trigger, a holdoff window blocks new triggers. The sequencer then re-arms and waits for A again.

States and transitions:
- `ST_ARMED` waits for the starting event:
  - In the A→B(n) mode, an A event moves it to `ST_COUNT_B` and clears the B count.
  - In the delay mode, an A event moves it to `ST_DELAY` and loads the delay.
  - In the two edge modes it fires directly from `ST_ARMED`.
- `ST_COUNT_B` fires when the B event count reaches n.
- `ST_DELAY` moves to `ST_WAIT_B` once the delay counter is zero.
- `ST_WAIT_B` fires on the first B event.
- Every fire moves to `ST_HOLDOFF` and loads the holdoff.
- `ST_HOLDOFF` returns to `ST_ARMED` once that counter is zero.

Top module: `pattern_trig_seq`

## Requirements
- R1: A condition is true when every bit with its care bit set (1) equals its level bit (1 = High, 0 = Low). Vector bits [15:0] are the channels and bit 16 is the external input. Bits with care 0 never matter.
- R2: With the on-exit select at 0, a condition's event is its change from false to true. With the select at 1, the event is its change from true to false. The other change is not an event.
- R3: In mode 0 (A then n-th B), the trigger fires on the n-th B event after an A event. A `count_n` of 0 behaves as 1. B events before an A event are not counted.
- R4: In mode 1 (A, delay, B), B events are ignored until `delay_ticks` ticks have been counted after the A event. The trigger then fires on the first B event.
- R5: In mode 2 (edge on A), the trigger fires when an enabled edge occurs on any bit while condition A is true. The same edge fires nothing while A is false.
- R6: In mode 3 (edge OR), the trigger fires on any bit's enabled rise (`rise_en`) or fall (`fall_en`), whatever A is. Edges on bits not enabled do nothing.
- R7: `trig` is high for exactly one clock cycle. It rises one clock after the cycle in which the firing event is presented.
- R8: After a trigger, no new trigger fires until `holdoff_ticks` ticks have been counted. Events during the holdoff are ignored.
- R9: After the holdoff the sequencer waits for a new A event, and the B count restarts from zero.
- R10: While `rst_n` is low, `trig` is 0. The sequencer leaves reset in `ST_ARMED`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | 500 ns time-base enable |
| ch_bits | input | 16 | Channel logic bits |
| ext_bit | input | 1 | External input bit |
| mode | input | 2 | 0 A→B(n), 1 A-delay-B, 2 edge on A, 3 edge OR |
| a_care | input | 17 | Condition A care mask |
| a_level | input | 17 | Condition A required levels |
| a_on_exit | input | 1 | Condition A event on exit |
| b_care | input | 17 | Condition B care mask |
| b_level | input | 17 | Condition B required levels |
| b_on_exit | input | 1 | Condition B event on exit |
| rise_en | input | 17 | Per-bit rising-edge enable |
| fall_en | input | 17 | Per-bit falling-edge enable |
| count_n | input | 8 | B event count n |
| delay_ticks | input | 21 | Post-A delay in ticks |
| holdoff_ticks | input | 21 | Holdoff in ticks |
| trig | output | 1 | One-cycle trigger pulse |

## Verification
The pattern tests drive condition A with a High bit, a Low bit, the external bit and a don't-care bit toggling. This separates a true match from a mismatch on each kind of cared bit.

The count tests apply B pulses before A, after A, and after a re-arm without a fresh A. This shows the count is qualified by A and restarts at zero. Swapping entry and exit selection, and setting n to 0, separates the two edge directions of an event.

The delay and holdoff tests place B events and edges one tick short of the programmed window and then just after it. This pins the window boundary. The edge tests separate enabled rises and falls from the opposite edge and from an unselected bit.

// File: rtl/ptseq_pkg.sv
package ptseq_pkg;
    typedef enum logic [1:0] {
        MODE_A_THEN_NB = 2'd0,
        MODE_A_DELAY_B = 2'd1,
        MODE_EDGE_ON_A = 2'd2,
        MODE_EDGE_OR   = 2'd3
    } trig_mode_e;

    typedef enum logic [2:0] {
        ST_ARMED   = 3'd0,
        ST_COUNT_B = 3'd1,
        ST_DELAY   = 3'd2,
        ST_WAIT_B  = 3'd3,
        ST_HOLDOFF = 3'd4
    } seq_state_e;
endpackage

// File: rtl/pattern_cond.sv
module pattern_cond #(
    parameter int NB = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] bits,
    input  logic [NB-1:0] care,
    input  logic [NB-1:0] level,
    input  logic          on_exit,
    output logic          cond,
    output logic          evt
);
    logic cond_q;

    // true when no cared bit differs from its requested level
    assign cond = ~|(care & (bits ^ level));

    always_ff @(posedge clk) begin
        if (!rst_n) cond_q <= 1'b0;
        else        cond_q <= cond;
    end

    assign evt = on_exit ? (~cond & cond_q) : (cond & ~cond_q);
endmodule

// File: rtl/edge_or_det.sv
module edge_or_det #(
    parameter int NB = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] bits,
    input  logic [NB-1:0] rise_en,
    input  logic [NB-1:0] fall_en,
    output logic          hit
);
    logic [NB-1:0] bits_q;

    always_ff @(posedge clk) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= bits;
    end

    assign hit = |((rise_en & bits & ~bits_q) | (fall_en & ~bits & bits_q));
endmodule

// File: rtl/tick_dcnt.sv
module tick_dcnt #(
    parameter int W = 21
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)                cnt <= '0;
        else if (load)             cnt <= load_val;
        else if (tick && cnt != 0) cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/pattern_trig_seq.sv
module pattern_trig_seq
    import ptseq_pkg::*;
#(
    parameter int NCH = 16,
    parameter int CW  = 21,
    parameter int NW  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [NCH-1:0]   ch_bits,
    input  logic             ext_bit,
    input  logic [1:0]       mode,
    input  logic [NCH:0]     a_care,
    input  logic [NCH:0]     a_level,
    input  logic             a_on_exit,
    input  logic [NCH:0]     b_care,
    input  logic [NCH:0]     b_level,
    input  logic             b_on_exit,
    input  logic [NCH:0]     rise_en,
    input  logic [NCH:0]     fall_en,
    input  logic [NW-1:0]    count_n,
    input  logic [CW-1:0]    delay_ticks,
    input  logic [CW-1:0]    holdoff_ticks,
    output logic             trig
);
    localparam int NB = NCH + 1;

    logic [NB-1:0] in_vec;
    logic          cond_a, cond_b, a_evt, b_evt, edge_hit, cnt_zero;
    logic          cnt_load, fire;
    logic [CW-1:0] cnt_val;
    seq_state_e    st, st_nxt;
    logic [NW-1:0] bcnt, bcnt_nxt;
    logic [NW:0]   n_eff;
    trig_mode_e    mode_e;

    assign in_vec = {ext_bit, ch_bits};
    assign mode_e = trig_mode_e'(mode);
    assign n_eff  = (count_n == '0) ? {{NW{1'b0}}, 1'b1} : {1'b0, count_n};

    pattern_cond #(.NB(NB)) u_cond_a (
        .clk(clk), .rst_n(rst_n), .bits(in_vec), .care(a_care),
        .level(a_level), .on_exit(a_on_exit), .cond(cond_a), .evt(a_evt)
    );

    pattern_cond #(.NB(NB)) u_cond_b (
        .clk(clk), .rst_n(rst_n), .bits(in_vec), .care(b_care),
        .level(b_level), .on_exit(b_on_exit), .cond(cond_b), .evt(b_evt)
    );

    edge_or_det #(.NB(NB)) u_edges (
        .clk(clk), .rst_n(rst_n), .bits(in_vec), .rise_en(rise_en),
        .fall_en(fall_en), .hit(edge_hit)
    );

    // shared between post-A delay and holdoff: the two never overlap
    tick_dcnt #(.W(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_val),
        .tick(tick), .zero(cnt_zero)
    );

    always_comb begin
        st_nxt   = st;
        bcnt_nxt = bcnt;
        fire     = 1'b0;
        cnt_load = 1'b0;
        cnt_val  = holdoff_ticks;
        unique case (st)
            ST_ARMED: begin
                unique case (mode_e)
                    MODE_A_THEN_NB: if (a_evt) begin
                        st_nxt   = ST_COUNT_B;
                        bcnt_nxt = '0;
                    end
                    MODE_A_DELAY_B: if (a_evt) begin
                        st_nxt   = ST_DELAY;
                        cnt_load = 1'b1;
                        cnt_val  = delay_ticks;
                    end
                    MODE_EDGE_ON_A: fire = edge_hit & cond_a;
                    MODE_EDGE_OR:   fire = edge_hit;
                    default: ;
                endcase
            end
            ST_COUNT_B: if (b_evt) begin
                if ({1'b0, bcnt} + 1'b1 >= n_eff) fire = 1'b1;
                else bcnt_nxt = bcnt + 1'b1;
            end
            ST_DELAY:   if (cnt_zero) st_nxt = ST_WAIT_B;
            ST_WAIT_B:  fire = b_evt;
            ST_HOLDOFF: if (cnt_zero) st_nxt = ST_ARMED;
            default:    st_nxt = ST_ARMED;
        endcase
        if (fire) begin
            st_nxt   = ST_HOLDOFF;
            cnt_load = 1'b1;
            cnt_val  = holdoff_ticks;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_ARMED;
            bcnt <= '0;
        end else begin
            st   <= st_nxt;
            bcnt <= bcnt_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trig <= 1'b0;
        else        trig <= fire;
    end
endmodule

// File: rtl/pattern_trig_seq_chk.sv
module pattern_trig_seq_chk
    import ptseq_pkg::*;
#(
    parameter int CW = 21,
    parameter int NW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick,
    input logic          trig,
    input logic [1:0]    mode,
    input logic          b_on_exit,
    input logic [NW-1:0] count_n,
    input logic [CW-1:0] holdoff_ticks,
    input logic          cond_a,
    input logic          cond_b,
    input logic          edge_hit,
    input seq_state_e    st,
    input logic [NW-1:0] bcnt
);
    logic [CW:0] since;
    logic        seen;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since <= '0;
            seen  <= 1'b0;
        end else if (trig) begin
            since <= {{CW{1'b0}}, tick};
            seen  <= 1'b1;
        end else if (tick && !(&since)) begin
            since <= since + 1'b1;
        end
    end

    a_r10_reset_quiet: assert property (@(posedge clk) !rst_n |=> !trig);

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> !trig);

    a_r8_holdoff_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && seen) |-> (since >= {1'b0, holdoff_ticks}));

    a_r5_edge_needs_a: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && mode == 2'd2) |-> ($past(cond_a) && $past(edge_hit)));

    a_r6_edge_or_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && mode == 2'd3) |-> $past(edge_hit));

    a_r4_fire_from_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && mode == 2'd1) |-> ($past(st) == ST_WAIT_B));

    a_r3_entry_b_true: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && mode == 2'd0 && !b_on_exit) |-> $past(cond_b));

    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_COUNT_B) |-> ({1'b0, bcnt} < ((count_n == '0) ? 9'd1 : {1'b0, count_n})));
endmodule

bind pattern_trig_seq pattern_trig_seq_chk #(.CW(CW), .NW(NW)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .trig(trig), .mode(mode),
    .b_on_exit(b_on_exit), .count_n(count_n), .holdoff_ticks(holdoff_ticks),
    .cond_a(cond_a), .cond_b(cond_b), .edge_hit(edge_hit), .st(st), .bcnt(bcnt)
);

// File: tb/tb_pattern_trig_seq.sv
module tb_pattern_trig_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [15:0] ch_bits = '0;
    logic        ext_bit = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [16:0] a_care = '0, a_level = '0, b_care = '0, b_level = '0;
    logic        a_on_exit = 1'b0, b_on_exit = 1'b0;
    logic [16:0] rise_en = '0, fall_en = '0;
    logic [7:0]  count_n = 8'd1;
    logic [20:0] delay_ticks = '0, holdoff_ticks = '0;
    logic        trig;
    int          checks = 0;
    int          fails = 0;

    always #2 clk = ~clk;

    pattern_trig_seq dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ch_bits(ch_bits), .ext_bit(ext_bit),
        .mode(mode), .a_care(a_care), .a_level(a_level), .a_on_exit(a_on_exit),
        .b_care(b_care), .b_level(b_level), .b_on_exit(b_on_exit),
        .rise_en(rise_en), .fall_en(fall_en), .count_n(count_n),
        .delay_ticks(delay_ticks), .holdoff_ticks(holdoff_ticks), .trig(trig)
    );

    task automatic chk(input logic got, input logic exp, input string tag);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: trig=%0b expected %0b", tag, got, exp);
        end
    endtask

    // drive one input vector (bit 16 = external) and check trig one clock later
    task automatic step(input logic [16:0] v, input logic tk, input logic exp, input string tag);
        @(negedge clk);
        ch_bits = v[15:0];
        ext_bit = v[16];
        tick    = tk;
        @(posedge clk);
        #1;
        chk(trig, exp, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tick = 1'b0; ch_bits = '0; ext_bit = 1'b0;
        repeat (2) @(negedge clk);
        chk(trig, 1'b0, "R10 trig low in reset");
        rst_n = 1'b1;
    endtask

    task automatic t_pattern();
        mode = 2'd2; a_care = 17'h10005; a_level = 17'h10001;
        rise_en = 17'h00020; fall_en = '0; holdoff_ticks = '0;
        do_reset();
        step(17'h10001, 0, 0, "R1 A true, no edge");
        step(17'h10201, 0, 0, "R1 don't-care bit toggled");
        step(17'h10221, 0, 1, "R5 enabled edge while A true");
        step(17'h10201, 0, 0, "R7 pulse ends");
        step(17'h10001, 0, 0, "R1 idle");
        step(17'h00021, 0, 0, "R1 ext mismatch blocks edge");
        step(17'h00001, 0, 0, "R1 idle");
        step(17'h10005, 0, 0, "R1 low-level bit high");
        step(17'h10025, 0, 0, "R5 edge with A false");
        step(17'h10001, 0, 0, "R1 idle");
        step(17'h10021, 0, 1, "R5 edge with A true again");
    endtask

    task automatic t_count();
        mode = 2'd0; a_care = 17'h1; a_level = 17'h1; b_care = 17'h2; b_level = 17'h2;
        a_on_exit = 0; b_on_exit = 0; count_n = 8'd3; holdoff_ticks = '0;
        do_reset();
        step(17'h2, 0, 0, "R3 B before A not counted");
        step(17'h0, 0, 0, "R3 idle");
        step(17'h1, 0, 0, "R3 A entry");
        step(17'h3, 0, 0, "R3 first B");
        step(17'h1, 0, 0, "R3 idle");
        step(17'h3, 0, 0, "R3 second B");
        step(17'h1, 0, 0, "R3 idle");
        step(17'h3, 0, 1, "R3 third B fires");
        step(17'h1, 0, 0, "R7 pulse ends");
        step(17'h1, 0, 0, "R9 re-armed");
        step(17'h3, 0, 0, "R9 B without new A");
        step(17'h1, 0, 0, "R9 idle");
        step(17'h0, 0, 0, "R9 A drops");
        step(17'h1, 0, 0, "R9 new A entry");
        step(17'h3, 0, 0, "R9 B one after restart");
        step(17'h1, 0, 0, "R9 idle");
        step(17'h3, 0, 0, "R9 B two after restart");
        step(17'h1, 0, 0, "R9 idle");
        step(17'h3, 0, 1, "R9 count restarted from zero");
    endtask

    task automatic t_exit();
        mode = 2'd0; count_n = 8'd1; a_on_exit = 0; b_on_exit = 1;
        do_reset();
        step(17'h1, 0, 0, "R2 A entry");
        step(17'h3, 0, 0, "R2 B entry ignored in exit mode");
        step(17'h1, 0, 1, "R2 B exit fires");
        a_on_exit = 1; b_on_exit = 0; count_n = 8'd0;
        do_reset();
        step(17'h1, 0, 0, "R2 A entry not an event in exit mode");
        step(17'h3, 0, 0, "R2 B before A exit");
        step(17'h2, 0, 0, "R2 A exit");
        step(17'h0, 0, 0, "R2 idle");
        step(17'h2, 0, 1, "R3 n of zero acts as one");
    endtask

    task automatic t_delay();
        mode = 2'd1; a_on_exit = 0; b_on_exit = 0; delay_ticks = 21'd3; holdoff_ticks = '0;
        do_reset();
        step(17'h1, 0, 0, "R4 A entry starts delay");
        step(17'h3, 0, 0, "R4 B during delay ignored");
        step(17'h1, 1, 0, "R4 tick 1");
        step(17'h1, 1, 0, "R4 tick 2");
        step(17'h3, 0, 0, "R4 B one tick short ignored");
        step(17'h1, 1, 0, "R4 tick 3");
        step(17'h1, 0, 0, "R4 delay expires");
        step(17'h3, 0, 1, "R4 first B after delay fires");
    endtask

    task automatic t_edge_or();
        mode = 2'd3; a_care = 17'h1; a_level = 17'h1;
        rise_en = 17'h00008; fall_en = 17'h10000; holdoff_ticks = '0;
        do_reset();
        step(17'h00008, 0, 1, "R6 enabled rise fires with A false");
        step(17'h00008, 0, 0, "R6 idle");
        step(17'h00000, 0, 0, "R6 fall on rise-only bit");
        step(17'h10000, 0, 0, "R6 rise on fall-only bit");
        step(17'h00000, 0, 1, "R6 enabled fall fires");
        step(17'h00000, 0, 0, "R6 idle");
        step(17'h00080, 0, 0, "R6 unselected bit edge");
    endtask

    task automatic t_holdoff();
        mode = 2'd3; rise_en = 17'h00008; fall_en = '0; holdoff_ticks = 21'd2;
        do_reset();
        step(17'h8, 0, 1, "R8 first trigger");
        step(17'h0, 0, 0, "R7 single-cycle pulse");
        step(17'h8, 0, 0, "R8 edge in holdoff ignored");
        step(17'h0, 1, 0, "R8 holdoff tick 1");
        step(17'h0, 1, 0, "R8 holdoff tick 2");
        step(17'h8, 0, 0, "R8 edge as holdoff ends ignored");
        step(17'h0, 0, 0, "R8 idle");
        step(17'h8, 0, 1, "R8 fires after holdoff");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        t_pattern();
        t_count();
        t_exit();
        t_delay();
        t_edge_or();
        t_holdoff();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule